// File: doc/BRIEF.md
# Modified Miller Bit Decoder

This block turns an oversampled modified Miller line into decoded bits. Each bit occupies a fixed window of `WIN` sample-clock cycles. A one carries a short low pulse that starts at mid-window. A zero carries a low pulse at the start of the window, but only when the bit before it was also a zero. A zero that follows a one shows no pulse at all, so the line stays high for that whole window. The decoder therefore keeps a register holding the last good bit, and it uses that history to judge whether a window with no pulse is legal.

Inside each window the line is sampled twice: once at offset `S1`, which falls inside a start-of-window pulse, and once at offset `S2`, which falls inside a mid-window pulse. The two samples form a pair. The pair is classified as rising, falling, constant high or constant low, and the class is combined with the history bit to give a result. The upstream framing logic raises `frame_start` for one cycle to mark the cycle before the first window. That pulse restarts the window timer and clears the history. After that, the timer keeps running. A falling edge that arrives near one of the two positions where a pulse may begin pulls the timer back into step, so slow clock drift does not build up from one window to the next.

Top module: `mm_decoder`

## Requirements
- R1: While `rst` is high, and afterwards until the first `frame_start`, `bit_valid`, `bit_val` and `bit_err` are 0, and no result is produced, whatever the line does.
- R2: A `frame_start` pulse in cycle c makes cycle c+1 offset 0 of a window. Windows are `WIN` cycles long, and the line is sampled at offsets `S1` and `S2`. The result appears as a one-cycle `bit_valid` in the cycle after offset `S2`.
- R3: A pair that is high at `S1` and low at `S2` (falling) decodes as `bit_val` = 1 with `bit_err` = 0.
- R4: A pair that is low at `S1` and high at `S2` (rising) decodes as `bit_val` = 0 with `bit_err` = 0.
- R5: A pair that is high at both samples decodes as `bit_val` = 0 with no error when the previous good bit was 1.
- R6: A pair that is high at both samples when the previous good bit was 0 sets `bit_err` = 1 with `bit_val` = 0.
- R7: A pair that is low at both samples sets `bit_err` = 1 with `bit_val` = 0.
- R8: A window flagged as an error leaves the stored previous bit unchanged.
- R9: `frame_start` clears the stored previous bit to 0 and discards any window in progress, so that window produces no result.
- R10: A falling edge seen while the timer is within `TOL` cycles of offset 0 (circularly) makes the next cycle offset 1. A falling edge seen within `TOL` cycles of offset `WIN/2` makes the next cycle offset `WIN/2`+1.
- R11: `bit_valid` lasts exactly one cycle per window, and `bit_err` is never high without `bit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse; the next cycle starts the first window |
| line_in | input | 1 | Demodulated line level, idle high |
| bit_valid | output | 1 | One-cycle strobe for each decoded window |
| bit_val | output | 1 | Decoded bit, 0 on an error |
| bit_err | output | 1 | Illegal waveform in this window |

## Verification
The bench uses the defaults: `WIN`=94, `S1`=24, `S2`=67, `TOL`=4. With these values a 40-cycle pulse covers `S1` at the start of a window and `S2` at mid-window. Windows of 97 and 91 cycles make the line drift by three cycles per bit, one run in each direction. After a few bits this drift would push the samples off the pulses, so both resynchronisation paths must work for those runs to decode cleanly. A fixed table of waveforms runs the history through every legal and illegal pairing.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // Sample pair {first, second}
    typedef enum logic [1:0] {
        PAIR_LOW  = 2'b00,
        PAIR_RISE = 2'b01,
        PAIR_FALL = 2'b10,
        PAIR_HIGH = 2'b11
    } pair_e;

    typedef struct packed {
        logic value;
        logic err;
    } decision_t;

    function automatic pair_e make_pair(logic first, logic second);
        return pair_e'({first, second});
    endfunction

    // Combine sample pair with the previous good bit.
    function automatic decision_t decide(pair_e p, logic prev_bit);
        decision_t d;
        d.value = 1'b0;
        d.err   = 1'b0;
        case (p)
            PAIR_FALL: d.value = 1'b1;
            PAIR_RISE: d.value = 1'b0;
            PAIR_HIGH: d.err   = ~prev_bit;
            default:   d.err   = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mm_edge_det.sv
module mm_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic fall
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b1;
        else     line_q <= line_in;
    end

    assign fall = line_q & ~line_in;

endmodule

// File: rtl/mm_bit_timer.sv
module mm_bit_timer #(
    parameter int WIN = 94,
    parameter int S1  = 24,
    parameter int S2  = 67,
    parameter int TOL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic fall,
    output logic samp1,
    output logic samp2
);
    localparam int CW = $clog2(WIN);
    localparam logic [CW-1:0] LAST_L = CW'(WIN - 1);
    localparam logic [CW-1:0] HALF_L = CW'(WIN / 2);
    localparam logic [CW-1:0] TOL_L  = CW'(TOL);
    localparam logic [CW-1:0] WRAP_L = CW'(WIN - TOL);
    localparam logic [CW-1:0] S1_L   = CW'(S1);
    localparam logic [CW-1:0] S2_L   = CW'(S2);
    localparam logic [CW-1:0] ONE_L  = CW'(1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          active_q;
    logic          near_start, near_mid;

    assign near_start = (cnt_q <= TOL_L) || (cnt_q >= WRAP_L);
    assign near_mid   = (cnt_q >= HALF_L - TOL_L) && (cnt_q <= HALF_L + TOL_L);

    always_comb begin
        cnt_d = cnt_q;
        if (frame_start)
            cnt_d = '0;
        else if (active_q) begin
            if (fall && near_start)
                cnt_d = ONE_L;
            else if (fall && near_mid)
                cnt_d = HALF_L + ONE_L;
            else if (cnt_q == LAST_L)
                cnt_d = '0;
            else
                cnt_d = cnt_q + ONE_L;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (frame_start) active_q <= 1'b1;
        end
    end

    assign samp1 = active_q && (cnt_q == S1_L);
    assign samp2 = active_q && (cnt_q == S2_L);

    assert_frame_restart_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (active_q && cnt_q == '0));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (cnt_q <= LAST_L));

    assert_mid_resync_R10: assert property (@(posedge clk) disable iff (rst)
        (active_q && !frame_start && fall && near_mid && !near_start) |=> (cnt_q == HALF_L + ONE_L));

endmodule

// File: rtl/mm_sampler.sv
module mm_sampler
    import mm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_in,
    input  logic  samp1,
    input  logic  samp2,
    output pair_e pair,
    output logic  pair_stb
);
    logic s1_q;

    always_ff @(posedge clk) begin
        if (rst)        s1_q <= 1'b1;
        else if (samp1) s1_q <= line_in;
    end

    assign pair     = make_pair(s1_q, line_in);
    assign pair_stb = samp2;

endmodule

// File: rtl/mm_history.sv
module mm_history
    import mm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_start,
    input  logic  pair_stb,
    input  pair_e pair,
    output logic  bit_valid,
    output logic  bit_val,
    output logic  bit_err
);
    logic      prev_q, valid_q, bit_q, err_q;
    decision_t dec;

    assign dec = decide(pair, prev_q);

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            prev_q  <= 1'b0;
            valid_q <= 1'b0;
            bit_q   <= 1'b0;
            err_q   <= 1'b0;
        end else if (pair_stb) begin
            valid_q <= 1'b1;
            bit_q   <= dec.value;
            err_q   <= dec.err;
            if (!dec.err) prev_q <= dec.value;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end
    end

    assign bit_valid = valid_q;
    assign bit_val   = bit_q;
    assign bit_err   = err_q;

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    assert_err_with_valid_R11: assert property (@(posedge clk) disable iff (rst)
        err_q |-> valid_q);

    assert_err_zero_bit_R6: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !bit_q);

    assert_prev_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !err_q) |-> (prev_q == bit_q));

    assert_high_needs_one_R5: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && pair_stb && pair == PAIR_HIGH && !prev_q) |=> err_q);

    assert_frame_clears_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!prev_q && !valid_q));

endmodule

// File: rtl/mm_decoder.sv
module mm_decoder
    import mm_pkg::*;
#(
    parameter int WIN = 94,
    parameter int S1  = 24,
    parameter int S2  = 67,
    parameter int TOL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_val,
    output logic bit_err
);
    logic  fall, samp1, samp2, pair_stb;
    pair_e pair;

    mm_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .fall    (fall)
    );

    mm_bit_timer #(.WIN(WIN), .S1(S1), .S2(S2), .TOL(TOL)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .fall        (fall),
        .samp1       (samp1),
        .samp2       (samp2)
    );

    mm_sampler u_samp (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .samp1    (samp1),
        .samp2    (samp2),
        .pair     (pair),
        .pair_stb (pair_stb)
    );

    mm_history u_hist (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .pair_stb    (pair_stb),
        .pair        (pair),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .bit_err     (bit_err)
    );

endmodule

// File: tb/sim_mm_decoder.sv
module sim_mm_decoder;
    localparam int WIN = 94;
    localparam int S2  = 67;
    localparam int K_ZP  = 0;   // zero with start pulse
    localparam int K_ONE = 1;   // one, mid pulse
    localparam int K_ZH  = 2;   // zero, no pulse
    localparam int K_LOW = 3;   // all low (illegal)
    localparam int NROWS = 14;
    // {kind[3:2], exp_bit[1], exp_err[0]}
    localparam logic [3:0] TABLE [NROWS] = '{
        4'b00_0_0, 4'b01_1_0, 4'b10_0_0, 4'b00_0_0, 4'b01_1_0,
        4'b01_1_0, 4'b10_0_0, 4'b10_0_1, 4'b00_0_0, 4'b01_1_0,
        4'b11_0_1, 4'b10_0_0, 4'b10_0_1, 4'b01_1_0
    };

    logic clk = 1'b0;
    logic rst, frame_start, line_in;
    logic bit_valid, bit_val, bit_err;
    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    mm_decoder #(.WIN(WIN)) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_in(line_in),
        .bit_valid(bit_valid), .bit_val(bit_val), .bit_err(bit_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic wave(input int kind, input int i);
        case (kind)
            K_ONE:   return !(i >= 47 && i < 87);
            K_ZP:    return !(i < 40);
            K_ZH:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1'b1;
        line_in = 1'b1;
    endtask

    // Drives one window; expects exactly nexp results (0 or 1).
    task automatic send_bit(input int kind, input int len, input int nexp,
                            input logic eb, input logic ee, input bit chk_pos,
                            input string req);
        int nvalid = 0;
        int pos = -1;
        logic gb = 0, ge = 0;
        bit stray = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (bit_valid) begin
                nvalid++; gb = bit_val; ge = bit_err; pos = i;
            end
            if (bit_err && !bit_valid) stray = 1;
            frame_start = 1'b0;
            line_in = wave(kind, i);
        end
        check(nvalid == nexp, {req, " R11 result count"}, nvalid, nexp);
        check(!stray, "R11 err without valid", stray, 0);
        if (nexp == 1) begin
            check(gb == eb, {req, " bit"}, gb, eb);
            check(ge == ee, {req, " err"}, ge, ee);
            if (chk_pos) check(pos == S2 + 1, "R2 result timing", pos, S2 + 1);
        end
    endtask

    initial begin
        rst = 1'b1; frame_start = 1'b0; line_in = 1'b1;
        repeat (3) @(negedge clk);
        check(bit_valid == 0, "R1 reset valid", bit_valid, 0);
        check(bit_val == 0,   "R1 reset bit",   bit_val, 0);
        check(bit_err == 0,   "R1 reset err",   bit_err, 0);
        rst = 1'b0;
        // R1: idle with pulses on the line but no frame: nothing
        send_bit(K_ONE, 2 * WIN, 0, 0, 0, 0, "R1 idle");

        // Table walk: R3 R4 R5 R6 R7 R8
        start_frame();
        for (int r = 0; r < NROWS; r++) begin
            send_bit(int'(TABLE[r][3:2]), WIN, 1, TABLE[r][1], TABLE[r][0], 1,
                     $sformatf("R3-R8 row%0d", r));
        end

        // R9: new frame clears the history bit
        start_frame();
        send_bit(K_ONE, WIN, 1, 1, 0, 1, "R3 before restart");
        start_frame();
        send_bit(K_ZH, WIN, 1, 0, 1, 1, "R9 history cleared");

        // R9: partial window abandoned by frame_start
        start_frame();
        send_bit(K_ONE, 60, 0, 0, 0, 0, "R9 partial window");
        start_frame();
        send_bit(K_ZP, WIN, 1, 0, 0, 1, "R9 after abandon");
        send_bit(K_ONE, WIN, 1, 1, 0, 1, "R3 after abandon");
        start_frame();
        send_bit(K_ONE, 60, 0, 0, 0, 0, "R9 partial window two");
        start_frame();
        send_bit(K_ZH, WIN, 1, 0, 1, 1, "R9 prev not taken from partial");

        // R10: slow sender, mid-window resync
        start_frame();
        for (int k = 0; k < 20; k++)
            send_bit(K_ONE, WIN + 3, 1, 1, 0, 0, $sformatf("R10 slow%0d", k));
        // R10: fast sender, start-of-window resync
        start_frame();
        for (int k = 0; k < 20; k++)
            send_bit(K_ZP, WIN - 3, 1, 0, 0, 0, $sformatf("R10 fast%0d", k));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule